// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one port of general-purpose pins (eight by default) behind a small register bus. Each pin has three control bits. A direction bit picks output or input. A data bit is the driven level when the pin is an output, and it enables the pull-up when the pin is an input. An input bit reads back the synchronized pad level. The block drives an output value, an output enable and a pull-up enable toward each pad, and it takes the pad level back in.

Software writes the direction and data registers at their own bus addresses. Writing ones to the input address flips the matching data bits. Reads are registered and come back on the cycle after the read strobe. A global pull-up-disable input turns off every pull-up. A sleep input forces the input synchronizer to a fixed low level, so a floating pad cannot make internal logic toggle. Reset is asynchronous, so the pads are tri-stated even when no clock is running.

Top module: `gpio_port_ctrl`

## Requirements
- R1: An active-low `rst_n` clears the direction bits, the data bits and `bus_rdata` at once, with no clock edge needed. While it is low, `pad_oe` and `pad_pu` are all zero.
- R2: A write to address 0 (`bus_wr` high at a rising edge) loads the direction register. A one in bit i makes pin i an output (`pad_oe[i]`=1), and a zero makes it an input (`pad_oe[i]`=0).
- R3: A write to address 1 loads the data register. When pin i is an output, `pad_out[i]` equals data bit i.
- R4: `pad_pu[i]` is 1 exactly when pin i is an input, its data bit is 1 and `pullup_dis` is 0.
- R5: A write to address 2 toggles each data bit whose write bit is 1. Data bits whose write bit is 0 keep their value.
- R6: A read (`bus_rd` high at a rising edge) puts the register selected by `bus_addr` on `bus_rdata` after that edge. Address 0 returns direction, address 1 returns data, address 2 returns the synchronized pins, and address 3 returns zero. `bus_rdata` holds its value between reads.
- R7: Take a pad level that is present while the clock is low before a rising edge. A read strobed at the next rising edge returns that level from address 2, not the data bits.
- R8: While `sleep_en` is high, the synchronizer input is forced to 0, and address 2 reads zero whatever the pad levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | PIN_COUNT | Write data |
| bus_rdata | output | PIN_COUNT | Registered read data |
| pullup_dis | input | 1 | Global pull-up disable |
| sleep_en | input | 1 | Forces synchronizer input low |
| pad_in | input | PIN_COUNT | Pad levels |
| pad_out | output | PIN_COUNT | Pad output values |
| pad_oe | output | PIN_COUNT | Pad output enables |
| pad_pu | output | PIN_COUNT | Pad pull-up enables |

## Verification
The direction and data registers are loaded with mixed patterns (such as 0x0F with 0xA5). This separates the output-enable path from the pull-up path bit by bit, because the output pins and the pulled-up inputs fall on different bits. The global pull-up disable is then toggled on that same pattern, and a sparse toggle mask is written to the input address. Together these show that only the masked bits flip and that the disable gates every pull-up. Pad patterns that differ from the data register (0x3C against 0xB4) show that reads of address 2 return the pins and not the data bits. An all-ones pad under sleep shows the forced-low input. Reset asserted between clock edges shows that the tri-state does not wait for a clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // Per-cycle access strobes decoded from the register bus
   typedef struct packed {
      logic wr_dir;
      logic wr_data;
      logic wr_pin;
      logic rd_dir;
      logic rd_data;
      logic rd_pin;
   } gpio_strobe_t;

   // Synchronizer construction choices
   typedef enum int {
      SYNC_LATCH_FLOP = 0,
      SYNC_TWO_FLOP   = 1
   } gpio_sync_kind_e;
endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_dir,
   input  logic         wr_data,
   input  logic         wr_pin,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (wr_data) begin
         data_q <= wdata;
      end else if (wr_pin) begin
         data_q <= data_q ^ wdata;
      end
   end

   // R2
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> dir_q == $past(wdata));

   // R5
   port_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pin && !wr_data) |=> data_q == ($past(data_q) ^ $past(wdata)));

   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_pin && !wr_data) |=> $stable(data_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W    = 8,
   parameter int KIND = gpio_pkg::SYNC_LATCH_FLOP
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sleep_en,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] sync_q
);
   logic [W-1:0] gated;

   // R8: a sleeping port presents a fixed low level to the first stage
   assign gated = sleep_en ? '0 : pad_in;

   generate
      if (KIND == gpio_pkg::SYNC_LATCH_FLOP) begin : g_latch
         logic [W-1:0] stage;
         always_latch begin
            if (!clk) stage = gated;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= stage;
         end
      end else begin : g_flop
         logic [W-1:0] stage;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage  <= '0;
               sync_q <= '0;
            end else begin
               stage  <= gated;
               sync_q <= stage;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int W = 8
) (
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] data_q,
   input  logic         pullup_dis,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_pu
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         assign pad_oe[i]  = dir_q[i];
         assign pad_out[i] = data_q[i];
         assign pad_pu[i]  = !dir_q[i] && data_q[i] && !pullup_dis;
      end
   endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
   parameter int PIN_COUNT = 8,
   parameter int ADDR_W    = 2,
   parameter int DIR_ADDR  = 0,
   parameter int DATA_ADDR = 1,
   parameter int PIN_ADDR  = 2,
   parameter int SYNC_KIND = gpio_pkg::SYNC_LATCH_FLOP
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [PIN_COUNT-1:0] bus_wdata,
   output logic [PIN_COUNT-1:0] bus_rdata,
   input  logic                 pullup_dis,
   input  logic                 sleep_en,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [PIN_COUNT-1:0] pad_pu
);
   import gpio_pkg::*;

   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(PIN_ADDR);

   generate
      if (PIN_COUNT < 1 || PIN_COUNT > 32) begin : g_bad_width
         $error("PIN_COUNT must lie in 1..32");
      end
      if (DIR_ADDR >= ADDR_SPAN || DATA_ADDR >= ADDR_SPAN || PIN_ADDR >= ADDR_SPAN) begin : g_bad_addr
         $error("register address outside ADDR_W span");
      end
      if (DIR_ADDR == DATA_ADDR || DIR_ADDR == PIN_ADDR || DATA_ADDR == PIN_ADDR) begin : g_dup_addr
         $error("register addresses must be distinct");
      end
      if (SYNC_KIND != SYNC_LATCH_FLOP && SYNC_KIND != SYNC_TWO_FLOP) begin : g_bad_kind
         $error("unknown SYNC_KIND");
      end
   endgenerate

   gpio_strobe_t stb;
   logic [PIN_COUNT-1:0] dir_q, data_q, sync_q;

   always_comb begin
      stb.wr_dir  = bus_wr && (bus_addr == A_DIR);
      stb.wr_data = bus_wr && (bus_addr == A_DATA);
      stb.wr_pin  = bus_wr && (bus_addr == A_PIN);
      stb.rd_dir  = bus_rd && (bus_addr == A_DIR);
      stb.rd_data = bus_rd && (bus_addr == A_DATA);
      stb.rd_pin  = bus_rd && (bus_addr == A_PIN);
   end

   gpio_reg_bank #(.W(PIN_COUNT)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_dir  (stb.wr_dir),
      .wr_data (stb.wr_data),
      .wr_pin  (stb.wr_pin),
      .wdata   (bus_wdata),
      .dir_q   (dir_q),
      .data_q  (data_q)
   );

   gpio_in_sync #(.W(PIN_COUNT), .KIND(SYNC_KIND)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep_en (sleep_en),
      .pad_in   (pad_in),
      .sync_q   (sync_q)
   );

   gpio_pad_drive #(.W(PIN_COUNT)) i_drive (
      .dir_q      (dir_q),
      .data_q     (data_q),
      .pullup_dis (pullup_dis),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .pad_pu     (pad_pu)
   );

   // Registered read return: one cycle after the strobe, held otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         unique case (1'b1)
            stb.rd_dir:  bus_rdata <= dir_q;
            stb.rd_data: bus_rdata <= data_q;
            stb.rd_pin:  bus_rdata <= sync_q;
            default:     bus_rdata <= '0;
         endcase
      end
   end

   // R6
   rd_dir_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.rd_dir |=> bus_rdata == $past(dir_q));

   // R7
   rd_pin_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.rd_pin |=> bus_rdata == $past(sync_q));

   // R6
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         pullup_dis = 1'b0;
   logic         sleep_en = 1'b0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out, pad_oe, pad_pu;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   gpio_port_ctrl i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pullup_dis(pullup_dis), .sleep_en(sleep_en), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
   );

   // Behavioural reference: what software would believe the port holds
   logic [W-1:0] m_dir, m_data, m_pin, m_rd;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir <= '0; m_data <= '0; m_pin <= '0; m_rd <= '0;
      end else begin
         if (bus_rd) begin
            case (bus_addr)
               2'd0:    m_rd <= m_dir;
               2'd1:    m_rd <= m_data;
               2'd2:    m_rd <= m_pin;
               default: m_rd <= '0;
            endcase
         end
         if (bus_wr && bus_addr == 2'd0) m_dir <= bus_wdata;
         if (bus_wr && bus_addr == 2'd1) m_data <= bus_wdata;
         if (bus_wr && bus_addr == 2'd2) m_data <= m_data ^ bus_wdata;
         m_pin <= sleep_en ? '0 : pad_in;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Compare on every clock, shortly after the rising edge
   always @(posedge clk) begin
      #2;
      if (!done) begin
         check(pad_oe == m_dir, "R2 pad_oe", pad_oe, m_dir);
         check((pad_out & m_dir) == (m_data & m_dir), "R3 pad_out", pad_out & m_dir, m_data & m_dir);
         check(pad_pu == (~m_dir & m_data & {W{!pullup_dis}}), "R4 pad_pu", pad_pu,
               ~m_dir & m_data & {W{!pullup_dis}});
         check(bus_rdata == m_rd, "R6 rdata", bus_rdata, m_rd);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #200000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'hFF);
      finish_run();
   end

   initial begin
      logic [W-1:0] v;
      #1;
      // R1 reset state while reset is held
      check(pad_oe == '0, "R1 reset oe", pad_oe, '0);
      check(bus_rdata == '0, "R1 reset rdata", bus_rdata, '0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      wr(2'd1, 8'hA5);
      wr(2'd0, 8'h0F);
      @(negedge clk);
      check(pad_oe == 8'h0F, "R2 dir 0F", pad_oe, 8'h0F);
      check((pad_out & pad_oe) == 8'h05, "R3 out bits", pad_out & pad_oe, 8'h05);
      check(pad_pu == 8'hA0, "R4 pull-ups", pad_pu, 8'hA0);
      pullup_dis = 1'b1;
      #1 check(pad_pu == 8'h00, "R4 global disable", pad_pu, 8'h00);
      pullup_dis = 1'b0;

      rd(2'd0, v);
      check(v == 8'h0F, "R6 read dir", v, 8'h0F);
      wr(2'd2, 8'h11);
      rd(2'd1, v);
      check(v == 8'hB4, "R5 toggle", v, 8'hB4);
      wr(2'd2, 8'h00);
      rd(2'd1, v);
      check(v == 8'hB4, "R5 zero mask no effect", v, 8'hB4);
      rd(2'd3, v);
      check(v == 8'h00, "R6 unmapped reads zero", v, 8'h00);
      repeat (3) @(negedge clk);
      check(bus_rdata == 8'h00, "R6 rdata held", bus_rdata, 8'h00);

      @(negedge clk);
      pad_in = 8'h3C;
      rd(2'd2, v);
      check(v == 8'h3C, "R7 pin read", v, 8'h3C);
      pad_in = 8'hC3;
      rd(2'd2, v);
      check(v == 8'hC3, "R7 pin change", v, 8'hC3);

      sleep_en = 1'b1;
      pad_in = 8'hFF;
      @(negedge clk);
      rd(2'd2, v);
      check(v == 8'h00, "R8 sleep forces low", v, 8'h00);
      sleep_en = 1'b0;
      @(negedge clk);
      rd(2'd2, v);
      check(v == 8'hFF, "R8 wake", v, 8'hFF);

      // R1 asynchronous reset between edges
      wr(2'd0, 8'h0F);
      wr(2'd1, 8'hFF);
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      check(pad_oe == '0, "R1 async oe", pad_oe, '0);
      check(pad_pu == '0, "R1 async pu", pad_pu, '0);
      check(bus_rdata == '0, "R1 async rdata", bus_rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule